// File: doc/BRIEF.md
# Double-Buffered Digital Output Port

This block is a 16-bit output port with two register stages. A host write always goes into a holding register, and the host can read that register back at any time. The pins are driven from a second register, and the second register is updated only by a transfer cycle that copies the holding word into it. How a cycle starts depends on the write. A normal write starts one on the next clock. A deferred write waits, and its cycle can then be started by a host cycle command or by an edge on an external trigger input. A polarity input selects whether the trigger acts on its rising or its falling edge.

The pins carry the driven word only while the output-enable flag is set. Each transfer cycle sets the flag. Three things clear it: reset, a system-disable pulse, and a low level on the synchronized external enable input. While the flag is clear, every pin sits at an idle level, and a strap input picks whether that level is low or high. During each transfer, a busy strobe and a gate strobe tell external logic that the pins have just been updated. When the transfer ends, a one-cycle done pulse is raised.

Top module: `staged_output_port`

## Requirements
- R1: A write (`wr_en_i`=1) loads `wr_data_i` into the holding register at that clock edge. From the next cycle on, `rd_data_o` shows the holding register.
- R2: A write with `wr_defer_i`=1 starts no transfer cycle. `lines_o`, `busy_o` and `gate_o` keep their values.
- R3: A write with `wr_defer_i`=0 starts a transfer on the following clock edge. That edge copies the holding register to the drive register and sets the enable flag, so `lines_o` equals the written word one edge after the write.
- R4: `cycle_cmd_i`=1 on an edge while no transfer is running starts a transfer at that same edge.
- R5: `ext_trig_i` passes through two synchronizer flops. With `trig_pol_i`=1 a rising edge starts a transfer, and with `trig_pol_i`=0 a falling edge does. The transfer takes place on the third clock edge after the input changes. The opposite edge has no effect.
- R6: `busy_o` and `gate_o` are high for exactly 2 cycles, starting right after the copying edge.
- R7: `cycle_done_o` is high for exactly one cycle: the first cycle in which `busy_o` is low again.
- R8: A trigger edge or a cycle command that arrives while `busy_o` is high is dropped. A normal write's transfer request made while busy is held and is carried out once the port is idle.
- R9: `sys_disable_i`=1 clears the enable flag at that edge, so `lines_o` shows the idle level. Both registers keep their contents, and the next transfer re-enables the pins with the holding word.
- R10: While the synchronized `ext_enable_i` is low, the enable flag is cleared and stays clear, even if transfers run.
- R11: When the flag is clear, every bit of `lines_o` equals `idle_high_i`. Reset clears both registers and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_defer_i | input | 1 | 1 = load holding register only, no transfer |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Holding register read-back |
| cycle_cmd_i | input | 1 | Host transfer command |
| sys_disable_i | input | 1 | System disable, forces idle level |
| ext_enable_i | input | 1 | Asynchronous external enable, active high |
| ext_trig_i | input | 1 | Asynchronous external trigger |
| trig_pol_i | input | 1 | 1 = rising edge triggers, 0 = falling |
| idle_high_i | input | 1 | Strap: idle level of the pins |
| lines_o | output | 16 | Output lines |
| busy_o | output | 1 | Transfer in progress |
| gate_o | output | 1 | Sample strobe for external logic |
| cycle_done_o | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
A vector walk mixes normal and deferred writes of different bit patterns. It shows that only the normal writes move the pins, while read-back follows every write. Trigger tests use each polarity with both edge directions, so an accepted edge can be told apart from an ignored one. One trigger is timed to land inside a busy window, with a different word already waiting in the holding register, and the pins must then keep the old word. Disable and external-enable tests check the idle level under both strap settings, and then check that a command restores the stored word.

// File: rtl/sop_pkg.sv
package sop_pkg;
  parameter int unsigned SOP_DATA_W      = 16;
  parameter int unsigned SOP_HOLD_CYC    = 2;
  parameter int unsigned SOP_SYNC_STAGES = 2;
endpackage

// File: rtl/sop_sync.sv
module sop_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sop_edge.sv
module sop_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;

  assign edge_o = rise_sel_i ? (lvl_i & ~lvl_q) : (~lvl_i & lvl_q);

  AST_EDGE_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o && $stable(rise_sel_i) |=> !edge_o); // R5
endmodule

// File: rtl/sop_seq.sv
module sop_seq #(
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_req_i,
  input  logic cmd_i,
  input  logic trig_i,
  output logic start_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          done_q;

  assign busy_o  = (cnt_q != '0);
  // cmd and trigger are dropped while busy; auto requests wait in pend_q
  assign start_o = !busy_o && (pend_q || cmd_i || trig_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          pend_q <= 1'b0;
    else if (auto_req_i)  pend_q <= 1'b1;
    else if (start_o)     pend_q <= 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)           cnt_q <= '0;
    else if (start_o)      cnt_q <= CW'(HOLD_CYC);
    else if (busy_o)       cnt_q <= cnt_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= (cnt_q == CW'(1));

  assign done_o = done_q;

  // checker: length of the busy window
  logic [CW:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) run_q <= '0;
    else         run_q <= busy_o ? run_q + 1'b1 : '0;

  AST_BUSY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_q < (CW+1)'(HOLD_CYC)); // R6
  AST_BUSY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == (CW+1)'(HOLD_CYC)); // R6
  AST_DONE_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
endmodule

// File: rtl/staged_output_port.sv
module staged_output_port
  import sop_pkg::*;
#(
  parameter int unsigned DATA_W      = SOP_DATA_W,
  parameter int unsigned HOLD_CYC    = SOP_HOLD_CYC,
  parameter int unsigned SYNC_STAGES = SOP_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_defer_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              cycle_cmd_i,
  input  logic              sys_disable_i,
  input  logic              ext_enable_i,
  input  logic              ext_trig_i,
  input  logic              trig_pol_i,
  input  logic              idle_high_i,
  output logic [DATA_W-1:0] lines_o,
  output logic              busy_o,
  output logic              gate_o,
  output logic              cycle_done_o
);
  logic [1:0]        sync_q;
  logic              ext_en_s, trig_s, trig_edge;
  logic              start, busy;
  logic [DATA_W-1:0] rank1_q, rank2_q;
  logic              en_q;

  sop_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ext_enable_i, ext_trig_i}),
    .q_o   (sync_q)
  );
  assign {ext_en_s, trig_s} = sync_q;

  sop_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (trig_s),
    .rise_sel_i(trig_pol_i),
    .edge_o    (trig_edge)
  );

  sop_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .auto_req_i(wr_en_i && !wr_defer_i),
    .cmd_i     (cycle_cmd_i),
    .trig_i    (trig_edge),
    .start_o   (start),
    .busy_o    (busy),
    .done_o    (cycle_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      rank1_q <= '0;
    else if (wr_en_i) rank1_q <= wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    rank2_q <= '0;
    else if (start) rank2_q <= rank1_q;

  // disable conditions win over a same-edge transfer
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                        en_q <= 1'b0;
    else if (sys_disable_i || !ext_en_s) en_q <= 1'b0;
    else if (start)                     en_q <= 1'b1;

  assign rd_data_o = rank1_q;
  assign lines_o   = en_q ? rank2_q : {DATA_W{idle_high_i}};
  assign busy_o    = busy;
  assign gate_o    = busy;

  AST_COPY_RANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> rank2_q == $past(rank1_q)); // R3
  AST_HOLD_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(rank2_q)); // R8
  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_disable_i |=> !en_q); // R9
  AST_DISABLE_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_disable_i && !wr_en_i |=> $stable(rank1_q)); // R9
  AST_EXT_LOW_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_en_s |=> !en_q); // R10
endmodule

// File: tb/staged_output_port_tb.sv
module staged_output_port_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, wr_defer = 1'b0, cycle_cmd = 1'b0, sys_disable = 1'b0;
  logic        ext_enable = 1'b1, ext_trig = 1'b0, trig_pol = 1'b1, idle_high = 1'b0;
  logic [15:0] wr_data = '0, rd_data, lines;
  logic        busy, gate, done;
  int          n_run = 0, n_fail = 0;
  logic [15:0] exp_lines;

  always #5 clk = ~clk;

  staged_output_port u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_defer_i(wr_defer),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .cycle_cmd_i(cycle_cmd),
    .sys_disable_i(sys_disable), .ext_enable_i(ext_enable), .ext_trig_i(ext_trig),
    .trig_pol_i(trig_pol), .idle_high_i(idle_high), .lines_o(lines),
    .busy_o(busy), .gate_o(gate), .cycle_done_o(done)
  );

  // {defer, data}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 16'hA5C3}, {1'b1, 16'h1234}, {1'b0, 16'hFFFF},
    {1'b1, 16'h0000}, {1'b0, 16'h0001}, {1'b0, 16'h8000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic write(input logic [15:0] d, input logic defer);
    wr_en = 1'b1; wr_defer = defer; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_defer = 1'b0;
  endtask

  task automatic cmd();
    cycle_cmd = 1'b1;
    @(negedge clk);
    cycle_cmd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    // R11 reset state
    chk("R11 reset lines", lines, 16'h0000);
    chk("R11 reset rd", rd_data, 16'h0000);
    chk("R6 reset busy", {15'd0, busy}, 16'd0);
    chk("R7 reset done", {15'd0, done}, 16'd0);
    rst_ni = 1'b1;
    idle(4);
    exp_lines = 16'h0000;

    // vector walk: R1 R2 R3
    for (int i = 0; i < 6; i++) begin
      write(VEC[i][15:0], VEC[i][16]);
      chk("R1 read-back", rd_data, VEC[i][15:0]);
      @(negedge clk);
      if (!VEC[i][16]) begin
        exp_lines = VEC[i][15:0];
        chk("R3 lines after normal write", lines, exp_lines);
      end else begin
        chk("R2 lines unchanged", lines, exp_lines);
        chk("R2 no busy", {15'd0, busy}, 16'd0);
      end
      idle(3);
    end

    // R6 R7 busy/gate/done timing
    write(16'h5A5A, 1'b0);
    chk("R6 busy pre", {15'd0, busy}, 16'd0);
    @(negedge clk);
    chk("R6 busy c1", {15'd0, busy}, 16'd1);
    chk("R6 gate c1", {15'd0, gate}, 16'd1);
    chk("R7 done c1", {15'd0, done}, 16'd0);
    @(negedge clk);
    chk("R6 busy c2", {15'd0, busy}, 16'd1);
    @(negedge clk);
    chk("R6 busy c3", {15'd0, busy}, 16'd0);
    chk("R6 gate c3", {15'd0, gate}, 16'd0);
    chk("R7 done c3", {15'd0, done}, 16'd1);
    @(negedge clk);
    chk("R7 done c4", {15'd0, done}, 16'd0);
    idle(2);

    // R4 command
    write(16'h0F0F, 1'b1);
    chk("R4 before cmd", lines, 16'h5A5A);
    cmd();
    chk("R4 after cmd", lines, 16'h0F0F);
    idle(4);

    // R5 rising trigger
    trig_pol = 1'b1;
    write(16'h3C3C, 1'b1);
    ext_trig = 1'b1;
    idle(2);
    chk("R5 rise not yet", lines, 16'h0F0F);
    @(negedge clk);
    chk("R5 rise taken", lines, 16'h3C3C);
    idle(4);
    // R5 falling trigger
    trig_pol = 1'b0;
    write(16'hC3C3, 1'b1);
    ext_trig = 1'b0;
    idle(3);
    chk("R5 fall taken", lines, 16'hC3C3);
    idle(4);
    // R5 opposite edge ignored
    write(16'h7777, 1'b1);
    ext_trig = 1'b1;
    idle(6);
    chk("R5 wrong edge ignored", lines, 16'hC3C3);
    trig_pol = 1'b1; ext_trig = 1'b0;
    idle(4);

    // R8 trigger during busy dropped
    wr_en = 1'b1; wr_defer = 1'b0; wr_data = 16'hAAAA; ext_trig = 1'b1;
    @(negedge clk);
    wr_defer = 1'b1; wr_data = 16'hBBBB;
    @(negedge clk);
    wr_en = 1'b0; wr_defer = 1'b0;
    idle(6);
    chk("R8 trigger in busy dropped", lines, 16'hAAAA);
    chk("R8 holding kept", rd_data, 16'hBBBB);
    ext_trig = 1'b0;
    idle(4);
    // R8 cmd during busy dropped
    write(16'h1111, 1'b0);
    @(negedge clk);
    write(16'h2222, 1'b1);
    cycle_cmd = 1'b1;
    @(negedge clk);
    cycle_cmd = 1'b0;
    idle(4);
    chk("R8 cmd in busy dropped", lines, 16'h1111);
    // R8 queued auto request
    write(16'h4444, 1'b0);
    write(16'h6666, 1'b0);
    idle(8);
    chk("R8 queued auto", lines, 16'h6666);

    // R9 system disable
    sys_disable = 1'b1;
    @(negedge clk);
    sys_disable = 1'b0;
    chk("R9 idle after disable", lines, 16'h0000);
    chk("R9 holding kept", rd_data, 16'h6666);
    idle_high = 1'b1;
    #1;
    chk("R11 idle high", lines, 16'hFFFF);
    idle_high = 1'b0;
    cmd();
    chk("R9 re-enable", lines, 16'h6666);
    idle(4);

    // R10 external enable
    ext_enable = 1'b0;
    idle(4);
    chk("R10 ext low idle", lines, 16'h0000);
    cmd();
    idle(3);
    chk("R10 stays idle", lines, 16'h0000);
    ext_enable = 1'b1;
    idle(4);
    chk("R10 not auto-restored", lines, 16'h0000);
    cmd();
    chk("R10 cmd restores", lines, 16'h6666);
    idle(4);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule